// File: doc/BRIEF.md
# Shadow Register Update Sequencer

This block keeps eight registers in an always-on domain consistent with their working copies on the main bus. The eight registers are six persistent words, an alarm word and a seconds word. Each bus write lands in the working copy and marks that register as stale. A copy engine then moves stale registers into the always-on shadow set, one per slow tick. When more than one register is stale, the lowest-numbered one goes first. The engine clears each stale flag once that register's copy is done.

Software reads a status word to follow this progress. It carries a per-register stale bitmap, so a driver can wait on one register, such as seconds before it reads the time, without waiting on the others. The status word also has a one-tick "just copied" bitmap, a block-present flag and two crystal-strap bits. The slow tick is an enable input. It stands in for the crossing into the always-on clock.

Top module: `shd_update_seq`

## Requirements
- R1: A write with `wr_en` high to an address from 0 to 7 stores `wr_data` in that working register, and the value reads back at the same address from the next cycle. The addresses are persistent 0 to 5 at 0 to 5, alarm at 6 and seconds at 7. The same write sets status bit 16+address.
- R2: A cycle with `slow_tick` high and at least one stale bit copies exactly one register: the lowest-numbered stale one. Its working value appears on `shadow_q[32*i +: 32]` after that edge, and its stale bit clears.
- R3: In cycles without `slow_tick`, no stale bit clears and `shadow_q` does not change.
- R4: After a write to seconds (address 7), status bit 23 stays set until the tick that copies seconds.
- R5: A second write to a register whose copy is still pending replaces the data and keeps its stale bit set. The later value is the one copied.
- R6: A write to a register in the same cycle as that register's copy puts the older value in the shadow and leaves the stale bit set. The next tick then copies the newer value.
- R7: Status bits 8 to 15 hold a one-hot mark of the register copied at the most recent slow tick, at bit 8+index. The mark lasts until the next slow tick. It is all zero if that tick copied nothing.
- R8: Reading address 8 returns the status word. Bit 31 is 1, bit 28 follows `xtal_32000`, bit 27 follows `xtal_32768`, and every bit not named in these requirements is 0.
- R9: Reset clears every stale bit, every copied mark, every working register and every shadow register.
- R10: A write to address 8 or above changes no working register and no stale bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle enable for a copy step |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 4 | Bus write address |
| wr_data | input | 32 | Bus write data |
| rd_addr | input | 4 | Bus read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| xtal_32000 | input | 1 | Strap: a 32000 Hz crystal is fitted |
| xtal_32768 | input | 1 | Strap: a 32768 Hz crystal is fitted |
| shadow_q | output | 256 | Always-on shadow words, register i at bits 32*i+31 to 32*i |

## Verification
The bench writes all eight registers at once and then ticks eight times. This exposes an engine that walks in the wrong order, copies two registers in one tick, or lets the copied mark linger: the stale and copied bitmaps would then drift from the expected diagonal pattern. A write and a copy of the same register in one edge is the sharpest case. A design that clears the flag after that edge would lose the newer value for good. A second write while a copy is pending must carry the later value. A seconds write queued behind a lower-numbered register must keep bit 23 high, or a polling driver would read stale time. The bench also writes to the status address and to unmapped addresses, and it asserts reset midway, to catch stray updates and incomplete clearing.

// File: rtl/shd_pkg.sv
package shd_pkg;
   // status word layout
   localparam int unsigned ST_PRESENT_BIT = 31;
   localparam int unsigned ST_X32000_BIT  = 28;
   localparam int unsigned ST_X32768_BIT  = 27;
   localparam int unsigned ST_STALE_LSB   = 16;
   localparam int unsigned ST_FRESH_LSB   = 8;
   localparam int unsigned ST_FIELD_W     = 8;
   localparam int unsigned ST_MIN_W       = 32;
endpackage

// File: rtl/shd_pick.sv
// Priority picker: grants one requesting register per step.
module shd_pick #(
   parameter int unsigned NREG      = 8,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NREG-1:0] req,
   output logic [NREG-1:0] gnt
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            gnt = '0;
            for (int i = NREG - 1; i >= 0; i--) begin
               if (req[i]) begin
                  gnt    = '0;
                  gnt[i] = 1'b1;
               end
            end
         end
      end else begin : g_high
         always_comb begin
            gnt = '0;
            for (int i = 0; i < NREG; i++) begin
               if (req[i]) begin
                  gnt    = '0;
                  gnt[i] = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/shd_bus_regs.sv
// Working copies on the bus side plus per-register stale flags.
module shd_bus_regs #(
   parameter int unsigned NREG = 8,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [NREG-1:0]    clr,
   output logic [NREG*DW-1:0] bus_q,
   output logic [NREG-1:0]    stale
);
   localparam int unsigned IDXW = (NREG > 1) ? $clog2(NREG) : 1;

   logic [NREG-1:0] hit;

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         hit[i] = wr_en && (wr_addr == AW'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_q <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (hit[i]) bus_q[i*DW +: DW] <= wr_data;
         end
      end
   end

   // a write in the same cycle as its clear wins: the newer data still needs a copy
   always_ff @(posedge clk) begin
      if (rst) stale <= '0;
      else     stale <= (stale & ~clr) | hit;
   end

   a_r1_write_marks: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_addr < AW'(NREG))) |=> stale[$past(wr_addr[IDXW-1:0])]);

   a_r3_no_clear_without_step: assert property (@(posedge clk) disable iff (rst)
      (clr == '0) |=> (($past(stale) & ~stale) == '0));

   a_r10_no_stray_update: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && (wr_addr < AW'(NREG))) && (clr == '0)) |=> ($stable(stale) && $stable(bus_q)));
endmodule

// File: rtl/shd_copy_engine.sv
// Moves the granted register into the always-on shadow set on a slow tick.
module shd_copy_engine #(
   parameter int unsigned NREG = 8,
   parameter int unsigned DW   = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               slow_tick,
   input  logic [NREG-1:0]    gnt,
   input  logic [NREG*DW-1:0] bus_q,
   output logic [NREG*DW-1:0] shadow,
   output logic [NREG-1:0]    fresh,
   output logic [NREG-1:0]    clr
);
   assign clr = slow_tick ? gnt : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow <= '0;
         fresh  <= '0;
      end else if (slow_tick) begin
         fresh <= gnt;
         for (int i = 0; i < NREG; i++) begin
            if (gnt[i]) shadow[i*DW +: DW] <= bus_q[i*DW +: DW];
         end
      end
   end

   a_r7_fresh_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fresh));

   a_r7_fresh_holds: assert property (@(posedge clk) disable iff (rst)
      !slow_tick |=> $stable(fresh));

   a_r3_shadow_holds: assert property (@(posedge clk) disable iff (rst)
      !slow_tick |=> $stable(shadow));

   a_r2_step_marks: assert property (@(posedge clk) disable iff (rst)
      (slow_tick && (gnt != '0)) |=> (fresh != '0));
endmodule

// File: rtl/shd_update_seq.sv
module shd_update_seq #(
   parameter int unsigned NREG      = 8,
   parameter int unsigned DW        = 32,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned AW       = $clog2(NREG) + 1,
   localparam int unsigned IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               slow_tick,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic [AW-1:0]      rd_addr,
   output logic [DW-1:0]      rd_data,
   input  logic               xtal_32000,
   input  logic               xtal_32768,
   output logic [NREG*DW-1:0] shadow_q
);
   import shd_pkg::*;

   localparam logic [AW-1:0] STATUS_ADDR = AW'(NREG);

   generate
      if (NREG < 2 || NREG > ST_FIELD_W) begin : g_bad_nreg
         $error("NREG must lie in 2..8 to fit the status bitmaps");
      end
      if (DW < ST_MIN_W) begin : g_bad_dw
         $error("DW must be at least 32 to hold the status word");
      end
   endgenerate

   logic [NREG*DW-1:0] bus_q;
   logic [NREG-1:0]    stale, gnt, fresh, clr;
   logic [DW-1:0]      status;

   shd_bus_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clr(clr), .bus_q(bus_q), .stale(stale)
   );

   shd_pick #(.NREG(NREG), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req(stale), .gnt(gnt)
   );

   shd_copy_engine #(.NREG(NREG), .DW(DW)) u_copy (
      .clk(clk), .rst(rst), .slow_tick(slow_tick), .gnt(gnt),
      .bus_q(bus_q), .shadow(shadow_q), .fresh(fresh), .clr(clr)
   );

   always_comb begin
      status                           = '0;
      status[ST_PRESENT_BIT]           = 1'b1;
      status[ST_X32000_BIT]            = xtal_32000;
      status[ST_X32768_BIT]            = xtal_32768;
      status[ST_STALE_LSB +: NREG]     = stale;
      status[ST_FRESH_LSB +: NREG]     = fresh;
   end

   always_comb begin
      if (rd_addr < STATUS_ADDR)       rd_data = bus_q[rd_addr[IDXW-1:0]*DW +: DW];
      else if (rd_addr == STATUS_ADDR) rd_data = status;
      else                             rd_data = '0;
   end

   a_r2_lowest_first: assert property (@(posedge clk) disable iff (rst)
      (slow_tick && (stale != '0) && LOW_FIRST) |->
         ((gnt != '0) && ((stale & (gnt - NREG'(1))) == '0)));

   a_r4_seconds_held: assert property (@(posedge clk) disable iff (rst)
      (stale[NREG-1] && !(slow_tick && gnt[NREG-1])) |=> stale[NREG-1]);

   a_r8_present: assert property (@(posedge clk) disable iff (rst)
      (rd_addr == STATUS_ADDR) |-> rd_data[ST_PRESENT_BIT]);
endmodule

// File: tb/sim_shd_update_seq.sv
`timescale 1ns/1ps
module sim_shd_update_seq;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         slow_tick = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   rd_addr = '0;
   logic [31:0]  rd_data;
   logic         xtal_32000 = 1'b1;
   logic         xtal_32768 = 1'b0;
   logic [255:0] shadow_q;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   shd_update_seq u0 (
      .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .xtal_32000(xtal_32000), .xtal_32768(xtal_32768),
      .shadow_q(shadow_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   function automatic logic [31:0] st_exp(input logic [7:0] stl, input logic [7:0] frs);
      st_exp = 32'h8000_0000 | (32'(xtal_32000) << 28) | (32'(xtal_32768) << 27)
               | (32'(stl) << 16) | (32'(frs) << 8);
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] sh(input int i);
      sh = shadow_q[i*32 +: 32];
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      rd(4'd8, d);  chk("R9 R8 status after reset", d, st_exp(8'h00, 8'h00));
      rd(4'd7, d);  chk("R9 working reg after reset", d, 32'h0);
      chk("R9 shadow after reset", shadow_q[31:0] | shadow_q[255:224], 32'h0);
   endtask

   task automatic t_straps();
      logic [31:0] d;
      xtal_32000 = 1'b0; xtal_32768 = 1'b1;
      rd(4'd8, d);  chk("R8 strap 32768", d, 32'h8800_0000);
      xtal_32000 = 1'b1; xtal_32768 = 1'b0;
      rd(4'd8, d);  chk("R8 strap 32000", d, 32'h9000_0000);
   endtask

   task automatic t_order();
      logic [31:0] d;
      for (int i = 0; i < 8; i++) wr(4'(i), 32'hA000_0000 + 32'(i) * 32'h111);
      rd(4'd8, d);  chk("R1 all stale", d, st_exp(8'hFF, 8'h00));
      for (int i = 0; i < 8; i++) begin
         rd(4'(i), d);
         chk("R1 readback", d, 32'hA000_0000 + 32'(i) * 32'h111);
      end
      idle(3);
      rd(4'd8, d);  chk("R3 no tick keeps stale", d, st_exp(8'hFF, 8'h00));
      chk("R3 no tick keeps shadow", sh(0), 32'h0);
      for (int k = 0; k < 8; k++) begin
         tick();
         rd(4'd8, d);
         chk("R2 R7 status after step", d, st_exp(8'(8'hFF << (k + 1)), 8'(1 << k)));
         chk("R2 shadow copied", sh(k), 32'hA000_0000 + 32'(k) * 32'h111);
         if (k < 7) chk("R2 next not yet copied", sh(k + 1), 32'h0);
         idle(2);
         rd(4'd8, d);
         chk("R7 mark held between ticks", d, st_exp(8'(8'hFF << (k + 1)), 8'(1 << k)));
      end
      tick();
      rd(4'd8, d);  chk("R7 empty tick clears mark", d, st_exp(8'h00, 8'h00));
   endtask

   task automatic t_seconds();
      logic [31:0] d;
      wr(4'd7, 32'h0000_1234);
      wr(4'd2, 32'h0000_0222);
      idle(4);
      rd(4'd8, d);  chk("R4 seconds pending", d, st_exp(8'h84, 8'h00));
      tick();
      rd(4'd8, d);  chk("R4 R2 lower first, seconds held", d, st_exp(8'h80, 8'h04));
      chk("R4 seconds shadow old", sh(7), 32'hA000_0777);
      tick();
      rd(4'd8, d);  chk("R4 seconds done", d, st_exp(8'h00, 8'h80));
      chk("R4 seconds shadow new", sh(7), 32'h0000_1234);
   endtask

   task automatic t_rewrite();
      logic [31:0] d;
      wr(4'd6, 32'h1111_0000);
      wr(4'd6, 32'h2222_0000);
      rd(4'd8, d);  chk("R5 still stale", d, st_exp(8'h40, 8'h80));
      tick();
      chk("R5 newest copied", sh(6), 32'h2222_0000);
      rd(4'd8, d);  chk("R5 stale cleared", d, st_exp(8'h00, 8'h40));
   endtask

   task automatic t_collide();
      logic [31:0] d;
      wr(4'd3, 32'h0000_00AA);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h0000_00BB; slow_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; slow_tick = 1'b0;
      chk("R6 shadow gets older", sh(3), 32'h0000_00AA);
      rd(4'd8, d);  chk("R6 stale kept", d, st_exp(8'h08, 8'h08));
      tick();
      chk("R6 newer copied next", sh(3), 32'h0000_00BB);
      rd(4'd8, d);  chk("R6 stale cleared", d, st_exp(8'h00, 8'h08));
   endtask

   task automatic t_ignore();
      logic [31:0] d;
      wr(4'd8, 32'hFFFF_FFFF);
      wr(4'd12, 32'hFFFF_FFFF);
      rd(4'd8, d);  chk("R10 status untouched", d, st_exp(8'h00, 8'h08));
      rd(4'd0, d);  chk("R10 reg0 untouched", d, 32'hA000_0000);
      rd(4'd4, d);  chk("R10 reg4 untouched", d, 32'hA000_0444);
   endtask

   task automatic t_reset_mid();
      logic [31:0] d;
      wr(4'd1, 32'h5555_5555);
      wr(4'd5, 32'h6666_6666);
      @(negedge clk); rst = 1'b1;
      idle(2);
      rst = 1'b0;
      rd(4'd8, d);  chk("R9 reset clears stale", d, st_exp(8'h00, 8'h00));
      rd(4'd5, d);  chk("R9 reset clears working", d, 32'h0);
      chk("R9 reset clears shadow", sh(3) | sh(6) | sh(7), 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(4);
      rst = 1'b0;
      idle(1);
      t_reset();
      t_straps();
      t_order();
      t_seconds();
      t_rewrite();
      t_collide();
      t_ignore();
      t_reset_mid();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule